// File: doc/BRIEF.md
# Two-Slot Parallel-Issue Integer Execute Core

This block executes a 64-bit instruction bundle that packs two 32-bit sub-instructions side by side. Both sub-instructions are decoded, read their operands, compute and write back within the same clock cycle, and the pair is retired as one unit. The supported work is register-register add, subtract, AND and OR, plus add-immediate and OR-immediate. Any slot may hold a no-operation when no independent work is available.

Operand reads for both slots come from the register state as it stood before the bundle. A slot therefore never observes the result its partner produces in the same bundle. Software that needs sequential behaviour places the dependent operation in the next bundle. Instruction fetch, branching, memory access and inter-bundle hazard handling live outside this block. A debug read port exposes any register combinationally. A sticky flag records that an unsupported encoding was seen.

Top module: `vliw2_core`

## Requirements
- R1: While `rst_ni` is low, and at the first edge after it rises, every register reads zero on the debug port and `illegal_o` is 0.
- R2: Both slots take their source operands from the register values held before the bundle. With r18=6 and r19=4, the bundle {slot1: sub r20,r18,r19 ; slot0: add r18,r18,r19} leaves r18=10 and r20=2.
- R3: R-type words (opcode bits [31:26]=0) decode rs=[25:21], rt=[20:16], rd=[15:11] and funct=[5:0]. The funct values are 0x20 add, 0x22 sub, 0x24 and, 0x25 or, and the result goes to rd. Add and sub wrap modulo 2^32 and raise nothing.
- R4: Opcode 0x08 (addi) adds the sign-extended imm[15:0] to rs. Opcode 0x0D (ori) ORs the zero-extended imm[15:0] with rs. Both write rt, and addi wraps modulo 2^32.
- R5: The all-zero 32-bit word is a no-operation that changes no register.
- R6: Register 0 always reads as zero, and writes aimed at it are discarded.
- R7: When both slots of one bundle write the same register, the value from slot 1 is kept.
- R8: When `bundle_vld_i` is low, the bundle contents change no register and do not set `illegal_o`.
- R9: A valid slot with an unsupported opcode, or an opcode-0 word with an unsupported funct, writes nothing. Such a slot sets `illegal_o`, which stays 1 until reset. The partner slot still executes.
- R10: Bundle bits [31:0] form slot 0 and bits [63:32] form slot 1.
- R11: Results of a valid bundle become visible on the debug port only after the rising clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low synchronous reset |
| bundle_i | input | 64 | Instruction bundle; slot 0 low word, slot 1 high word |
| bundle_vld_i | input | 1 | Bundle is valid and executes at the next edge |
| dbg_addr_i | input | 5 | Register index for the debug read |
| dbg_data_o | output | 32 | Current value of the selected register |
| illegal_o | output | 1 | Sticky unsupported-encoding flag |

## Verification
The bundle patterns are chosen so that each one separates a specific fault. One pair reads a register that its partner rewrites, which separates a pre-bundle operand read from a forwarded one. Repeating the same code with the dependent operation moved to the next bundle proves that sequential behaviour appears only across bundles. Patterns with the two slots writing one register, writes to register 0, all-ones immediates and wrapping sums separate slot priority, the zero register and the two immediate extensions. Invalid bundles, and bundles that pair an illegal encoding with a legal one, show that only a valid bundle has an effect and that a legal partner still completes.

// File: rtl/vliw_pkg.sv
`timescale 1ns/1ps
package vliw_pkg;

    localparam int XLEN    = 32;
    localparam int INSTR_W = 32;
    localparam int REG_AW  = 5;
    localparam int IMM_W   = 16;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_ORI   = 6'h0D;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic              wr_en;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
        logic              use_imm;
        logic [XLEN-1:0]   imm;
        alu_op_e           op;
        logic              illegal;
    } slot_dec_t;

endpackage

// File: rtl/vliw_slot_decode.sv
`timescale 1ns/1ps
module vliw_slot_decode
    import vliw_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output slot_dec_t          dec_o
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [5:0]        opc;
    logic [5:0]        funct;
    logic [REG_AW-1:0] f_rs;
    logic [REG_AW-1:0] f_rt;
    logic [REG_AW-1:0] f_rd;
    logic [IMM_W-1:0]  f_imm;

    assign opc   = instr_i[31:26];
    assign f_rs  = instr_i[25:21];
    assign f_rt  = instr_i[20:16];
    assign f_rd  = instr_i[15:11];
    assign funct = instr_i[5:0];
    assign f_imm = instr_i[15:0];

    always_comb begin
        dec_o         = '0;
        dec_o.op      = ALU_ADD;
        dec_o.src_a   = f_rs;
        dec_o.src_b   = f_rt;
        if (instr_i != '0) begin
            unique case (opc)
                OPC_RTYPE: begin
                    dec_o.dst = f_rd;
                    unique case (funct)
                        FN_ADD:  begin dec_o.wr_en = 1'b1; dec_o.op = ALU_ADD; end
                        FN_SUB:  begin dec_o.wr_en = 1'b1; dec_o.op = ALU_SUB; end
                        FN_AND:  begin dec_o.wr_en = 1'b1; dec_o.op = ALU_AND; end
                        FN_OR:   begin dec_o.wr_en = 1'b1; dec_o.op = ALU_OR;  end
                        default: dec_o.illegal = 1'b1;
                    endcase
                end
                OPC_ADDI: begin
                    dec_o.wr_en   = 1'b1;
                    dec_o.dst     = f_rt;
                    dec_o.use_imm = 1'b1;
                    dec_o.imm     = {{EXT_W{f_imm[IMM_W-1]}}, f_imm};
                    dec_o.op      = ALU_ADD;
                end
                OPC_ORI: begin
                    dec_o.wr_en   = 1'b1;
                    dec_o.dst     = f_rt;
                    dec_o.use_imm = 1'b1;
                    dec_o.imm     = {{EXT_W{1'b0}}, f_imm};
                    dec_o.op      = ALU_OR;
                end
                default: dec_o.illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/vliw_slot_alu.sv
`timescale 1ns/1ps
module vliw_slot_alu
    import vliw_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);

    always_comb begin
        unique case (op_i)
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/vliw_regfile.sv
`timescale 1ns/1ps
module vliw_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int NUM_RD   = 4,
    parameter int NUM_WR   = 2,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [NUM_RD-1:0][AW-1:0]         rd_addr_i,
    output logic [NUM_RD-1:0][DATA_W-1:0]     rd_data_o,
    input  logic [NUM_WR-1:0]                 wr_en_i,
    input  logic [NUM_WR-1:0][AW-1:0]         wr_addr_i,
    input  logic [NUM_WR-1:0][DATA_W-1:0]     wr_data_i,
    input  logic [AW-1:0]                     dbg_addr_i,
    output logic [DATA_W-1:0]                 dbg_data_o
);

    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    // Higher-numbered write ports are applied last and therefore win.
    always_comb begin
        regs_d = regs_q;
        for (int w = 0; w < NUM_WR; w++) begin
            if (wr_en_i[w] && (wr_addr_i[w] != '0)) begin
                regs_d[wr_addr_i[w]] = wr_data_i[w];
            end
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                regs_q[r] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_data_o[p] = (rd_addr_i[p] == '0) ? '0 : regs_q[rd_addr_i[p]];
    end

    assign dbg_data_o = (dbg_addr_i == '0) ? '0 : regs_q[dbg_addr_i];

endmodule

// File: rtl/vliw2_core.sv
`timescale 1ns/1ps
module vliw2_core
    import vliw_pkg::*;
#(
    parameter int NUM_SLOTS  = 2,
    parameter int NUM_REGS   = 32,
    localparam int BUNDLE_W  = NUM_SLOTS * INSTR_W,
    localparam int AW        = $clog2(NUM_REGS),
    localparam int NUM_RD    = 2 * NUM_SLOTS
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [BUNDLE_W-1:0] bundle_i,
    input  logic                bundle_vld_i,
    input  logic [AW-1:0]       dbg_addr_i,
    output logic [XLEN-1:0]     dbg_data_o,
    output logic                illegal_o
);

    typedef struct packed {
        logic illegal;
    } core_state_t;

    slot_dec_t                         dec   [NUM_SLOTS];
    logic [XLEN-1:0]                   opnd_b[NUM_SLOTS];
    logic [XLEN-1:0]                   alu_y [NUM_SLOTS];

    logic [NUM_RD-1:0][AW-1:0]         rd_addr;
    logic [NUM_RD-1:0][XLEN-1:0]       rd_data;
    logic [NUM_SLOTS-1:0]              wr_en;
    logic [NUM_SLOTS-1:0][AW-1:0]      wr_addr;
    logic [NUM_SLOTS-1:0][XLEN-1:0]    wr_data;

    core_state_t state_d;
    core_state_t state_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        vliw_slot_decode u_dec (
            .instr_i (bundle_i[s*INSTR_W +: INSTR_W]),
            .dec_o   (dec[s])
        );

        assign opnd_b[s] = dec[s].use_imm ? dec[s].imm : rd_data[2*s+1];

        vliw_slot_alu #(.DATA_W(XLEN)) u_alu (
            .op_i (dec[s].op),
            .a_i  (rd_data[2*s]),
            .b_i  (opnd_b[s]),
            .y_o  (alu_y[s])
        );
    end

    // Port wiring and next-state computation.
    always_comb begin
        state_d = state_q;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            rd_addr[2*s]   = AW'(dec[s].src_a);
            rd_addr[2*s+1] = AW'(dec[s].src_b);
            wr_en[s]       = bundle_vld_i & dec[s].wr_en;
            wr_addr[s]     = AW'(dec[s].dst);
            wr_data[s]     = alu_y[s];
            if (bundle_vld_i && dec[s].illegal) begin
                state_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    vliw_regfile #(
        .DATA_W   (XLEN),
        .NUM_REGS (NUM_REGS),
        .NUM_RD   (NUM_RD),
        .NUM_WR   (NUM_SLOTS)
    ) u_rf (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .dbg_addr_i (dbg_addr_i),
        .dbg_data_o (dbg_data_o)
    );

    assign illegal_o = state_q.illegal;

endmodule

// File: rtl/vliw2_core_chk.sv
`timescale 1ns/1ps
module vliw2_core_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [63:0] bundle_i,
    input logic        bundle_vld_i,
    input logic [4:0]  dbg_addr_i,
    input logic [31:0] dbg_data_o,
    input logic        illegal_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> !illegal_o);

    // R6
    zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_addr_i == 5'd0) |-> (dbg_data_o == 32'd0));

    // R8
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bundle_vld_i |=> (!$stable(dbg_addr_i) || $stable(dbg_data_o)));

    // R8
    idle_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bundle_vld_i |=> !$rose(illegal_o));

    // R5
    nop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bundle_vld_i && bundle_i == 64'd0) |=>
        (!$stable(dbg_addr_i) || $stable(dbg_data_o)));

    // R5
    nop_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bundle_vld_i && bundle_i == 64'd0) |=> !$rose(illegal_o));

    // R9
    sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |=> illegal_o);

endmodule

bind vliw2_core vliw2_core_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bundle_i     (bundle_i),
    .bundle_vld_i (bundle_vld_i),
    .dbg_addr_i   (dbg_addr_i),
    .dbg_data_o   (dbg_data_o),
    .illegal_o    (illegal_o)
);

// File: tb/vliw2_core_tb_top.sv
`timescale 1ns/1ps
module vliw2_core_tb_top;

    logic        clk_i        = 1'b0;
    logic        rst_ni       = 1'b0;
    logic [63:0] bundle_i     = '0;
    logic        bundle_vld_i = 1'b0;
    logic [4:0]  dbg_addr_i   = '0;
    logic [31:0] dbg_data_o;
    logic        illegal_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk_i = ~clk_i;

    vliw2_core dut_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .bundle_i     (bundle_i),
        .bundle_vld_i (bundle_vld_i),
        .dbg_addr_i   (dbg_addr_i),
        .dbg_data_o   (dbg_data_o),
        .illegal_o    (illegal_o)
    );

    function automatic logic [31:0] rtype(input logic [5:0] fn, input logic [4:0] rd,
                                          input logic [4:0] rs, input logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] opc, input logic [4:0] rt,
                                          input logic [4:0] rs, input logic [15:0] imm);
        return {opc, rs, rt, imm};
    endfunction

    localparam logic [31:0] NOPW = 32'd0;
    localparam int NV = 15;

    // {requirement number, bundle {slot1, slot0}, register to read, expected}
    localparam logic [104:0] VEC [NV] = '{
        // R4: ori zero-extends small immediates
        {4'd4,  itype(6'h0D, 5'd19, 5'd0, 16'd4),  itype(6'h0D, 5'd18, 5'd0, 16'd6), 5'd18, 32'd6},
        // R5: all-zero bundle leaves r19 intact
        {4'd5,  NOPW, NOPW, 5'd19, 32'd4},
        // R2: partner reads pre-bundle r18, so r20 = 6 - 4
        {4'd2,  rtype(6'h22, 5'd20, 5'd18, 5'd19), rtype(6'h20, 5'd18, 5'd18, 5'd19), 5'd20, 32'd2},
        // R3: add result in r18
        {4'd3,  NOPW, NOPW, 5'd18, 32'd10},
        // R3: sub in its own bundle sees the new r18
        {4'd3,  NOPW, rtype(6'h22, 5'd20, 5'd18, 5'd19), 5'd20, 32'd6},
        // R3: or of 10 and 4
        {4'd3,  rtype(6'h25, 5'd22, 5'd18, 5'd19), rtype(6'h24, 5'd21, 5'd18, 5'd19), 5'd22, 32'd14},
        // R3: and of 10 and 4
        {4'd3,  NOPW, NOPW, 5'd21, 32'd0},
        // R4: addi sign-extends 0xFFFF
        {4'd4,  itype(6'h0D, 5'd24, 5'd0, 16'hFFFF), itype(6'h08, 5'd23, 5'd0, 16'hFFFF), 5'd23, 32'hFFFF_FFFF},
        // R4: ori zero-extends 0xFFFF
        {4'd4,  NOPW, NOPW, 5'd24, 32'h0000_FFFF},
        // R3: add wraps
        {4'd3,  rtype(6'h22, 5'd26, 5'd0, 5'd19), rtype(6'h20, 5'd25, 5'd23, 5'd19), 5'd25, 32'd3},
        // R3: sub wraps below zero
        {4'd3,  NOPW, NOPW, 5'd26, 32'hFFFF_FFFC},
        // R7: both slots write r27, slot 1 kept
        {4'd7,  itype(6'h0D, 5'd27, 5'd0, 16'h22), itype(6'h0D, 5'd27, 5'd0, 16'h11), 5'd27, 32'h22},
        // R6: writes to r0 discarded
        {4'd6,  itype(6'h08, 5'd0, 5'd0, 16'd7), itype(6'h0D, 5'd0, 5'd0, 16'd5), 5'd0, 32'd0},
        // R10: low word is slot 0
        {4'd10, itype(6'h0D, 5'd29, 5'd0, 16'd6), itype(6'h0D, 5'd28, 5'd0, 16'd5), 5'd28, 32'd5},
        // R10: high word is slot 1
        {4'd10, NOPW, NOPW, 5'd29, 32'd6}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] b, input logic v);
        @(negedge clk_i);
        bundle_i     = b;
        bundle_vld_i = v;
        @(negedge clk_i);
        bundle_i     = '0;
        bundle_vld_i = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        dbg_addr_i = a;
        #1;
        d = dbg_data_o;
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] acc;

        repeat (3) @(negedge clk_i);
        // R1: reset clears every register and the flag
        acc = '0;
        for (int r = 0; r < 32; r++) begin
            peek(r[4:0], rd);
            acc = acc | rd;
        end
        check("R1 registers in reset", acc, 32'd0);
        check("R1 flag in reset", {31'd0, illegal_o}, 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 flag after release", {31'd0, illegal_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][100:37], 1'b1);
            peek(VEC[i][36:32], rd);
            check($sformatf("R%0d vector %0d", VEC[i][104:101], i), rd, VEC[i][31:0]);
        end

        // R8: invalid bundle has no effect
        apply({itype(6'h3F, 5'd1, 5'd0, 16'd0), itype(6'h0D, 5'd18, 5'd0, 16'h77)}, 1'b0);
        peek(5'd18, rd);
        check("R8 invalid bundle writes nothing", rd, 32'd10);
        check("R8 invalid bundle sets no flag", {31'd0, illegal_o}, 32'd0);

        // R11: result not visible before the edge, visible after
        @(negedge clk_i);
        bundle_i     = {NOPW, itype(6'h0D, 5'd17, 5'd0, 16'h55)};
        bundle_vld_i = 1'b1;
        peek(5'd17, rd);
        check("R11 before edge", rd, 32'd0);
        @(posedge clk_i);
        #1;
        rd = dbg_data_o;
        check("R11 after edge", rd, 32'h55);
        @(negedge clk_i);
        bundle_i     = '0;
        bundle_vld_i = 1'b0;

        // R9: illegal slot 0 (opcode 0x3F, rt=r18) with legal slot 1
        apply({itype(6'h0D, 5'd30, 5'd0, 16'd9), itype(6'h3F, 5'd18, 5'd0, 16'h1234)}, 1'b1);
        check("R9 flag set", {31'd0, illegal_o}, 32'd1);
        peek(5'd18, rd);
        check("R9 illegal slot writes nothing", rd, 32'd10);
        peek(5'd30, rd);
        check("R9 partner executes", rd, 32'd9);
        apply('0, 1'b1);
        check("R9 flag sticky", {31'd0, illegal_o}, 32'd1);

        // R9: opcode 0 with unsupported funct 0x21 in slot 1
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        check("R1 flag cleared by reset", {31'd0, illegal_o}, 32'd0);
        peek(5'd18, rd);
        check("R1 register cleared by reset", rd, 32'd0);
        apply({rtype(6'h21, 5'd5, 5'd0, 5'd0), NOPW}, 1'b1);
        check("R9 bad funct flag", {31'd0, illegal_o}, 32'd1);
        peek(5'd5, rd);
        check("R9 bad funct writes nothing", rd, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule